// File: doc/BRIEF.md
# Packet Buffer Page Allocator

This block manages a packet buffer split into 256-byte pages. The host issues one-byte commands. They reserve space for a packet, give space back, and move packet numbers between a transmit queue and a receive queue. When an allocation is granted, the block hands out the lowest free packet number. It records the page count for that packet, so a later free returns exactly those pages to the pool.

The MAC side pushes numbers of received packets into the receive queue and pops numbers of packets it has sent from the transmit queue. The host sees both queue heads in one 16-bit word that carries an empty flag for each queue. It also sees the allocation outcome, a busy flag while a free is in progress, and a word giving the free and total page counts. A one-cycle done pulse after each allocation is provided for an external interrupt block.

Top module: `pkt_page_alloc`

## Requirements
- R1: After reset `allocResult` is 0x80, `busy` and `allocDone` are 0, both bytes of `memInfo` equal NUM_PAGES, and `fifoPorts` is 0x8080.
- R2: The command word holds the opcode in bits 7:5. Opcode 001 allocates (pages requested minus one) in bits 4:0. Two clock edges after the command is taken, `allocResult` holds the lowest free packet number with bit 7 clear, `allocDone` is high for exactly one cycle, and the free page count (`memInfo[15:8]`) has dropped by the page count.
- R3: If too few pages are free, or no packet number is free, an allocation sets `allocResult` to 0x80 and leaves the free page count unchanged.
- R4: Opcode 101 frees the packet named on `pktNum`. `busy` is high for exactly the two cycles after the command, and the packet's recorded page count returns to the pool. Freeing a number that is not allocated changes nothing.
- R5: Opcode 110 appends `pktNum` to the transmit queue. Its head appears in `fifoPorts[6:0]`, and `fifoPorts[7]` is 1 when the queue is empty. A `txPop` pulse removes the head, so entries leave in the order they were appended.
- R6: A `rxPush` pulse appends `rxPushNum` to the receive queue. Its head appears in `fifoPorts[14:8]`, and `fifoPorts[15]` is 1 when the queue is empty.
- R7: Opcode 011 drops the receive head without returning any pages.
- R8: Opcode 100 drops the receive head and frees that packet, with the same two-cycle `busy` as R4.
- R9: Opcode 010 frees every page and every packet number and empties both queues. It also sets `allocResult` to 0x80.
- R10: Opcode 111 empties only the transmit queue. The receive queue and the free page count are unchanged.
- R11: An append to a full queue and a removal from an empty queue are ignored.
- R12: A command given while a free or an allocation is still in progress is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmdValid | input | 1 | Command strobe, one cycle per command |
| cmdWord | input | 8 | Opcode in 7:5, page count minus one in 4:0 |
| pktNum | input | PKT_W | Packet number used by free and enqueue |
| rxPush | input | 1 | MAC appends a received packet number |
| rxPushNum | input | PKT_W | Number appended by rxPush |
| txPop | input | 1 | MAC removes the transmit head |
| busy | output | 1 | Free in progress |
| allocDone | output | 1 | One-cycle pulse when an allocation completes |
| allocResult | output | 8 | Bit 7 marks failure, otherwise the granted number |
| memInfo | output | 16 | Free pages in 15:8, total pages in 7:0 |
| fifoPorts | output | 16 | RX empty, RX head, TX empty, TX head |

## Verification
The bench builds the block with NUM_PAGES=12, MAX_PKTS=4 and QDEPTH=4. Each limit can then be reached in a few commands. A twelve-page pool runs dry after two allocations. Four packet numbers let an allocation fail for lack of a number while pages remain. Four queue slots make the full-queue drop reachable. The narrow number space also makes reuse of the lowest freed number directly visible.

// File: rtl/ppa_pkg.sv
package ppa_pkg;

  typedef enum logic [2:0] {
    CMD_NOP     = 3'b000,
    CMD_ALLOC   = 3'b001,
    CMD_RESET   = 3'b010,
    CMD_REMOVE  = 3'b011,
    CMD_RELFREE = 3'b100,
    CMD_FREEPKT = 3'b101,
    CMD_ENQ     = 3'b110,
    CMD_RSTTX   = 3'b111
  } ppa_cmd_e;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_ALLOC = 2'd1,
    ST_FREE1 = 2'd2,
    ST_FREE2 = 2'd3
  } ppa_state_e;

  typedef struct packed {
    logic doAlloc;
    logic doFree;
    logic popRx;
    logic pushTx;
    logic clrTx;
    logic clrAll;
  } ppa_strobe_t;

  localparam int unsigned RESULT_FAIL = 8'h80;

endpackage

// File: rtl/ppa_queue.sv
module ppa_queue #(
  parameter int W     = 6,
  parameter int DEPTH = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clear,
  input  logic         push,
  input  logic [W-1:0] pushData,
  input  logic         pop,
  output logic         empty,
  output logic         full,
  output logic [W-1:0] head
);
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CNT_W = $clog2(DEPTH + 1);
  localparam logic [PTR_W-1:0] LAST = PTR_W'(DEPTH - 1);

  logic [W-1:0]     mem [DEPTH];
  logic [PTR_W-1:0] rdPtr, wrPtr;
  logic [CNT_W-1:0] count;
  logic             doPop, doPush;

  assign empty  = (count == '0);
  assign full   = (count == CNT_W'(DEPTH));
  assign doPop  = pop && !empty;
  assign doPush = push && (!full || doPop);
  assign head   = empty ? '0 : mem[rdPtr];

  always_ff @(posedge clk) begin
    if (!rst_n || clear) begin
      rdPtr <= '0;
      wrPtr <= '0;
      count <= '0;
    end else begin
      if (doPush) begin
        mem[wrPtr] <= pushData;
        wrPtr      <= (wrPtr == LAST) ? '0 : wrPtr + 1'b1;
      end
      if (doPop) rdPtr <= (rdPtr == LAST) ? '0 : rdPtr + 1'b1;
      if (doPush && !doPop)      count <= count + 1'b1;
      else if (doPop && !doPush) count <= count - 1'b1;
    end
  end
endmodule

// File: rtl/ppa_ctrl.sv
module ppa_ctrl
  import ppa_pkg::*;
#(
  parameter int PKT_W = 6,
  parameter int REQ_W = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cmdValid,
  input  logic [7:0]       cmdWord,
  input  logic [PKT_W-1:0] pktNum,
  input  logic             rxEmpty,
  input  logic [PKT_W-1:0] rxHead,
  output ppa_strobe_t      strb,
  output logic [PKT_W-1:0] opNum,
  output logic [REQ_W-1:0] reqCode,
  output logic             busy,
  output logic             idle
);
  ppa_state_e state;
  ppa_cmd_e   code;
  logic       accept;

  assign code   = ppa_cmd_e'(cmdWord[7:5]);
  assign idle   = (state == ST_IDLE);
  assign busy   = (state == ST_FREE1) || (state == ST_FREE2);
  assign accept = cmdValid && idle;

  always_comb begin
    strb = '0;
    if (accept) begin
      unique case (code)
        CMD_RESET:   strb.clrAll = 1'b1;
        CMD_REMOVE,
        CMD_RELFREE: strb.popRx  = !rxEmpty;
        CMD_ENQ:     strb.pushTx = 1'b1;
        CMD_RSTTX:   strb.clrTx  = 1'b1;
        default:     ;
      endcase
    end
    strb.doAlloc = (state == ST_ALLOC);
    strb.doFree  = (state == ST_FREE1);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state   <= ST_IDLE;
      opNum   <= '0;
      reqCode <= '0;
    end else begin
      unique case (state)
        ST_IDLE: if (accept) begin
          if (code == CMD_ALLOC) begin
            state   <= ST_ALLOC;
            reqCode <= cmdWord[REQ_W-1:0];
          end else if (code == CMD_FREEPKT) begin
            state <= ST_FREE1;
            opNum <= pktNum;
          end else if (code == CMD_RELFREE && !rxEmpty) begin
            state <= ST_FREE1;
            opNum <= rxHead;
          end
        end
        ST_ALLOC: state <= ST_IDLE;
        ST_FREE1: state <= ST_FREE2;
        ST_FREE2: state <= ST_IDLE;
        default:  state <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/ppa_datapath.sv
module ppa_datapath
  import ppa_pkg::*;
#(
  parameter int NUM_PAGES = 32,
  parameter int MAX_PKTS  = 32,
  parameter int PKT_W     = 6,
  parameter int REQ_W     = 5,
  parameter int QDEPTH    = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  ppa_strobe_t      strb,
  input  logic [PKT_W-1:0] opNum,
  input  logic [REQ_W-1:0] reqCode,
  input  logic [PKT_W-1:0] pktNum,
  input  logic             rxPush,
  input  logic [PKT_W-1:0] rxPushNum,
  input  logic             txPop,
  output logic [7:0]       allocResult,
  output logic             allocDone,
  output logic [7:0]       freePages,
  output logic             rxEmpty,
  output logic [PKT_W-1:0] rxHead,
  output logic             txEmpty,
  output logic [PKT_W-1:0] txHead
);
  localparam int IDX_W = (MAX_PKTS > 1) ? $clog2(MAX_PKTS) : 1;
  localparam int CNT_W = REQ_W + 1;

  logic [MAX_PKTS-1:0] live;
  logic [CNT_W-1:0]    pageCnt [MAX_PKTS];
  logic [7:0]          freeCnt;
  logic [IDX_W-1:0]    pick, opIdx;
  logic                found, allocOk, freeOk;
  logic [CNT_W-1:0]    need;
  logic                rxFull, txFull;

  always_comb begin
    pick  = '0;
    found = 1'b0;
    for (int i = MAX_PKTS - 1; i >= 0; i--) begin
      if (!live[i]) begin
        pick  = IDX_W'(i);
        found = 1'b1;
      end
    end
  end

  assign need    = {1'b0, reqCode} + 1'b1;
  assign allocOk = found && (freeCnt >= 8'(need));
  assign opIdx   = opNum[IDX_W-1:0];
  assign freeOk  = (32'(opNum) < MAX_PKTS) && live[opIdx];
  assign freePages = freeCnt;

  always_ff @(posedge clk) begin
    if (!rst_n || strb.clrAll) begin
      live        <= '0;
      freeCnt     <= 8'(NUM_PAGES);
      allocResult <= 8'(RESULT_FAIL);
      allocDone   <= 1'b0;
      for (int i = 0; i < MAX_PKTS; i++) pageCnt[i] <= '0;
    end else begin
      allocDone <= strb.doAlloc;
      if (strb.doAlloc) begin
        if (allocOk) begin
          live[pick]    <= 1'b1;
          pageCnt[pick] <= need;
          freeCnt       <= freeCnt - 8'(need);
          allocResult   <= 8'(pick);
        end else begin
          allocResult <= 8'(RESULT_FAIL);
        end
      end else if (strb.doFree && freeOk) begin
        live[opIdx] <= 1'b0;
        freeCnt     <= freeCnt + 8'(pageCnt[opIdx]);
      end
    end
  end

  ppa_queue #(.W(PKT_W), .DEPTH(QDEPTH)) u_rxq (
    .clk(clk), .rst_n(rst_n), .clear(strb.clrAll),
    .push(rxPush), .pushData(rxPushNum), .pop(strb.popRx),
    .empty(rxEmpty), .full(rxFull), .head(rxHead)
  );

  ppa_queue #(.W(PKT_W), .DEPTH(QDEPTH)) u_txq (
    .clk(clk), .rst_n(rst_n), .clear(strb.clrAll || strb.clrTx),
    .push(strb.pushTx), .pushData(pktNum), .pop(txPop),
    .empty(txEmpty), .full(txFull), .head(txHead)
  );

  logic unusedFull;
  assign unusedFull = rxFull ^ txFull;
endmodule

// File: rtl/pkt_page_alloc.sv
module pkt_page_alloc
  import ppa_pkg::*;
#(
  parameter int NUM_PAGES = 32,
  parameter int MAX_PKTS  = 32,
  parameter int PKT_W     = 6,
  parameter int QDEPTH    = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cmdValid,
  input  logic [7:0]       cmdWord,
  input  logic [PKT_W-1:0] pktNum,
  input  logic             rxPush,
  input  logic [PKT_W-1:0] rxPushNum,
  input  logic             txPop,
  output logic             busy,
  output logic             allocDone,
  output logic [7:0]       allocResult,
  output logic [15:0]      memInfo,
  output logic [15:0]      fifoPorts
);
  localparam int REQ_W = 5;

  ppa_strobe_t      strb;
  logic [PKT_W-1:0] opNum, rxHead, txHead;
  logic [REQ_W-1:0] reqCode;
  logic             rxEmpty, txEmpty, ctrlIdle;
  logic [7:0]       freePages;

  ppa_ctrl #(.PKT_W(PKT_W), .REQ_W(REQ_W)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .cmdValid(cmdValid), .cmdWord(cmdWord),
    .pktNum(pktNum), .rxEmpty(rxEmpty), .rxHead(rxHead),
    .strb(strb), .opNum(opNum), .reqCode(reqCode),
    .busy(busy), .idle(ctrlIdle)
  );

  ppa_datapath #(
    .NUM_PAGES(NUM_PAGES), .MAX_PKTS(MAX_PKTS), .PKT_W(PKT_W),
    .REQ_W(REQ_W), .QDEPTH(QDEPTH)
  ) u_dp (
    .clk(clk), .rst_n(rst_n), .strb(strb), .opNum(opNum), .reqCode(reqCode),
    .pktNum(pktNum), .rxPush(rxPush), .rxPushNum(rxPushNum), .txPop(txPop),
    .allocResult(allocResult), .allocDone(allocDone), .freePages(freePages),
    .rxEmpty(rxEmpty), .rxHead(rxHead), .txEmpty(txEmpty), .txHead(txHead)
  );

  assign memInfo   = {freePages, 8'(NUM_PAGES)};
  assign fifoPorts = {rxEmpty, 7'(rxHead), txEmpty, 7'(txHead)};
endmodule

// File: rtl/ppa_checker.sv
module ppa_checker (
  input logic        clk,
  input logic        rst_n,
  input logic        busy,
  input logic        allocDone,
  input logic [7:0]  allocResult,
  input logic [15:0] memInfo,
  input logic [15:0] fifoPorts,
  input logic        ctrlIdle,
  input logic        cmdValid,
  input logic [7:0]  cmdWord
);
  AST_BUSY_MIN: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |=> busy); // R4
  AST_BUSY_MAX: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy)) |=> !busy); // R8
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    allocDone |=> !allocDone); // R2
  AST_GRANT_TAKES: assert property (@(posedge clk) disable iff (!rst_n)
    (allocDone && !allocResult[7]) |-> (memInfo[15:8] < $past(memInfo[15:8]))); // R2
  AST_FAIL_KEEPS: assert property (@(posedge clk) disable iff (!rst_n)
    (allocDone && allocResult[7]) |-> (memInfo[15:8] == $past(memInfo[15:8]))); // R3
  AST_FREE_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    memInfo[15:8] <= memInfo[7:0]); // R4
  AST_RESET_ALL: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrlIdle && cmdValid && cmdWord[7:5] == 3'b010)
      |=> (memInfo[15:8] == memInfo[7:0] && fifoPorts[15] && fifoPorts[7])); // R9
  AST_RSTTX_PAGES: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrlIdle && cmdValid && cmdWord[7:5] == 3'b111)
      |=> ($stable(memInfo[15:8]) && fifoPorts[7])); // R10
endmodule

bind pkt_page_alloc ppa_checker u_ppa_checker (
  .clk(clk), .rst_n(rst_n), .busy(busy), .allocDone(allocDone),
  .allocResult(allocResult), .memInfo(memInfo), .fifoPorts(fifoPorts),
  .ctrlIdle(ctrlIdle), .cmdValid(cmdValid), .cmdWord(cmdWord)
);

// File: tb/pkt_page_alloc_tb.sv
module pkt_page_alloc_tb;
  localparam int CLK_PERIOD = 10;
  localparam int PKT_W = 6;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cmdValid = 1'b0;
  logic [7:0] cmdWord = '0;
  logic [PKT_W-1:0] pktNum = '0;
  logic rxPush = 1'b0;
  logic [PKT_W-1:0] rxPushNum = '0;
  logic txPop = 1'b0;
  logic busy, allocDone;
  logic [7:0] allocResult;
  logic [15:0] memInfo, fifoPorts;

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  pkt_page_alloc #(.NUM_PAGES(12), .MAX_PKTS(4), .PKT_W(PKT_W), .QDEPTH(4)) u_dut (
    .clk(clk), .rst_n(rst_n), .cmdValid(cmdValid), .cmdWord(cmdWord),
    .pktNum(pktNum), .rxPush(rxPush), .rxPushNum(rxPushNum), .txPop(txPop),
    .busy(busy), .allocDone(allocDone), .allocResult(allocResult),
    .memInfo(memInfo), .fifoPorts(fifoPorts)
  );

  task automatic chk(input string req, input string what,
                     input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual=0x%0h expected=0x%0h", req, what, act, exp);
    end
  endtask

  // Returns at the falling edge just after the command was taken.
  task automatic issue(input logic [7:0] cmd);
    @(negedge clk);
    cmdValid = 1'b1;
    cmdWord  = cmd;
    @(negedge clk);
    cmdValid = 1'b0;
  endtask

  task automatic allocCheck(input string req, input logic [7:0] cmd,
                            input logic [7:0] expRes, input logic [15:0] expMem);
    issue(cmd);
    chk(req, "done early", 16'(allocDone), 16'h0);
    @(negedge clk);
    chk(req, "done", 16'(allocDone), 16'h1);
    chk(req, "result", 16'(allocResult), 16'(expRes));
    chk(req, "memInfo", memInfo, expMem);
    @(negedge clk);
    chk(req, "done pulse", 16'(allocDone), 16'h0);
  endtask

  task automatic freeCheck(input string req, input logic [7:0] cmd,
                           input logic [PKT_W-1:0] num, input logic [15:0] expMem);
    pktNum = num;
    issue(cmd);
    chk(req, "busy c1", 16'(busy), 16'h1);
    @(negedge clk);
    chk(req, "busy c2", 16'(busy), 16'h1);
    @(negedge clk);
    chk(req, "busy end", 16'(busy), 16'h0);
    chk(req, "memInfo", memInfo, expMem);
  endtask

  task automatic macPush(input logic [PKT_W-1:0] num);
    @(negedge clk);
    rxPush = 1'b1;
    rxPushNum = num;
    @(negedge clk);
    rxPush = 1'b0;
  endtask

  task automatic macPop();
    @(negedge clk);
    txPop = 1'b1;
    @(negedge clk);
    txPop = 1'b0;
  endtask

  task automatic enq(input logic [PKT_W-1:0] num);
    pktNum = num;
    issue(8'hC0);
  endtask

  task automatic t_reset_state();
    chk("R1", "allocResult", 16'(allocResult), 16'h0080);
    chk("R1", "busy", 16'(busy), 16'h0);
    chk("R1", "allocDone", 16'(allocDone), 16'h0);
    chk("R1", "memInfo", memInfo, 16'h0C0C);
    chk("R1", "fifoPorts", fifoPorts, 16'h8080);
  endtask

  task automatic t_alloc_free();
    allocCheck("R2", 8'h23, 8'h00, 16'h080C);
    allocCheck("R2", 8'h27, 8'h01, 16'h000C);
    allocCheck("R3 pages", 8'h20, 8'h80, 16'h000C);
    freeCheck("R4", 8'hA0, 6'd0, 16'h040C);
    allocCheck("R2 lowest", 8'h20, 8'h00, 16'h030C);
    freeCheck("R4 not live", 8'hA0, 6'd5, 16'h030C);
    freeCheck("R4", 8'hA0, 6'd1, 16'h0B0C);
    freeCheck("R4", 8'hA0, 6'd0, 16'h0C0C);
  endtask

  task automatic t_number_exhaust();
    allocCheck("R2", 8'h20, 8'h00, 16'h0B0C);
    allocCheck("R2", 8'h20, 8'h01, 16'h0A0C);
    allocCheck("R2", 8'h20, 8'h02, 16'h090C);
    allocCheck("R2", 8'h20, 8'h03, 16'h080C);
    allocCheck("R3 numbers", 8'h20, 8'h80, 16'h080C);
    macPush(6'd2);
    enq(6'd1);
    issue(8'h40);
    chk("R9", "memInfo", memInfo, 16'h0C0C);
    chk("R9", "fifoPorts", fifoPorts, 16'h8080);
    chk("R9", "allocResult", 16'(allocResult), 16'h0080);
    allocCheck("R9 numbers back", 8'h20, 8'h00, 16'h0B0C);
    issue(8'h40);
  endtask

  task automatic t_tx_queue();
    enq(6'd3);
    chk("R5", "tx head", fifoPorts, 16'h8003);
    enq(6'd7);
    enq(6'd9);
    enq(6'd11);
    enq(6'd13);
    chk("R11 full", "tx head", fifoPorts, 16'h8003);
    macPop();
    chk("R5", "tx 2nd", fifoPorts, 16'h8007);
    macPop();
    chk("R5", "tx 3rd", fifoPorts, 16'h8009);
    macPop();
    chk("R5", "tx 4th", fifoPorts, 16'h800B);
    macPop();
    chk("R11 dropped", "tx empty", fifoPorts, 16'h8080);
    macPop();
    chk("R11 pop empty", "tx empty", fifoPorts, 16'h8080);
  endtask

  task automatic t_rx_queue();
    macPush(6'd5);
    chk("R6", "rx head", fifoPorts, 16'h0580);
    macPush(6'd6);
    chk("R6", "rx head kept", fifoPorts, 16'h0580);
    issue(8'h60);
    chk("R7", "rx next", fifoPorts, 16'h0680);
    chk("R7", "memInfo", memInfo, 16'h0C0C);
    chk("R7", "busy", 16'(busy), 16'h0);
    issue(8'h60);
    chk("R7", "rx empty", fifoPorts, 16'h8080);
    issue(8'h60);
    chk("R11 remove empty", "fifoPorts", fifoPorts, 16'h8080);
    chk("R11 remove empty", "busy", 16'(busy), 16'h0);
  endtask

  task automatic t_release_free();
    allocCheck("R8", 8'h22, 8'h00, 16'h090C);
    macPush(6'd0);
    chk("R8", "rx head", fifoPorts, 16'h0080);
    freeCheck("R8", 8'h80, 6'd3, 16'h0C0C);
    chk("R8", "rx empty", fifoPorts, 16'h8080);
  endtask

  task automatic t_reset_tx();
    allocCheck("R10", 8'h21, 8'h00, 16'h0A0C);
    enq(6'd0);
    macPush(6'd4);
    chk("R10", "before", fifoPorts, 16'h0400);
    issue(8'hE0);
    chk("R10", "fifoPorts", fifoPorts, 16'h0480);
    chk("R10", "memInfo", memInfo, 16'h0A0C);
    issue(8'h40);
    chk("R9", "fifoPorts", fifoPorts, 16'h8080);
    chk("R9", "memInfo", memInfo, 16'h0C0C);
  endtask

  task automatic t_busy_ignore();
    allocCheck("R12", 8'h20, 8'h00, 16'h0B0C);
    pktNum = 6'd0;
    issue(8'hA0);
    chk("R12", "busy", 16'(busy), 16'h1);
    cmdValid = 1'b1;
    cmdWord  = 8'h21;
    @(negedge clk);
    cmdValid = 1'b0;
    chk("R12", "allocDone", 16'(allocDone), 16'h0);
    @(negedge clk);
    chk("R12", "busy end", 16'(busy), 16'h0);
    chk("R12", "allocDone", 16'(allocDone), 16'h0);
    @(negedge clk);
    chk("R12", "allocDone late", 16'(allocDone), 16'h0);
    chk("R12", "allocResult", 16'(allocResult), 16'h0000);
    chk("R12", "memInfo", memInfo, 16'h0C0C);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset_state();
    t_alloc_free();
    t_number_exhaust();
    t_tx_queue();
    t_rx_queue();
    t_release_free();
    t_reset_tx();
    t_busy_ignore();
    finished = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule